// File: doc/BRIEF.md
# SMM Memory and TSEG Access Router

This block is the system-management memory control point of a host bridge. It holds two small control registers and a 16-bit extended-size word. From their contents it sorts every memory access into one of three destinations: main DRAM, the PCI side, or a black hole. The black hole returns all ones on reads and drops writes. Three regions are governed: the legacy 128 KB SMM window at 0xA0000, a high alias of that window at 0xFEDA0000, and a TSEG region placed just under the top of low memory.

Each access carries an address, a write flag and an SMM-mode flag. One cycle later the block returns the chosen destination, together with the write flag. A lock bit freezes both control registers until reset and closes the non-SMM view of SMRAM. The extended-size word lets software discover the configured extended TSEG size by writing a query value.

Top module: `smm_route_ctrl`

## Requirements
- R1: After reset, the main control register (select 0) and the extended control register (select 1) read 0. The size word (select 2) reads 0xFFFF when EXT_MB is nonzero and 0 otherwise.
- R2: An access with acc_valid high yields rsp_valid high on the next cycle, with rsp_route coded 0 = DRAM, 1 = PCI, 2 = black hole, and never 3. Outside the three regions, addresses below LOW_TOP go to DRAM and all others go to PCI.
- R3: Main control bit 2 is the open bit. A non-SMM access to 0xA0000..0xBFFFF goes to DRAM only when open is set and the high-enable bit (extended control bit 3) is clear. Otherwise it goes to PCI.
- R4: A non-SMM access to 0xFEDA0000..0xFEDBFFFF goes to DRAM only when open and high-enable are both set. Otherwise it goes to PCI.
- R5: Main control bit 0 is the global SMRAM enable. While it is set, an SMM access reaches DRAM in the low window when high-enable is clear, and in the high alias when high-enable is set. In every other case an SMM access to these windows is routed as a non-SMM access would be.
- R6: Extended control bit 0 enables TSEG. Bits 2:1 select its size: 0 = 1 MB, 1 = 2 MB, 2 = 8 MB, 3 = EXT_MB megabytes. An EXT_MB of 0 gives no TSEG.
- R7: When TSEG is enabled, addresses in [LOW_TOP - size, LOW_TOP) go to the black hole for non-SMM reads and writes, and to DRAM for SMM accesses.
- R8: Main control bit 1 is the lock bit. A write that sets lock stores open as 0 in the same write. Once lock is set, writes to selects 0 and 1 change nothing, and only reset clears the lock.
- R9: Writing 0xFFFF to the size word loads EXT_MB instead, when EXT_MB is nonzero. Any other value, or any value when EXT_MB is 0, is stored as written.
- R10: A configuration write changes the routing of an access presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 main control, 1 extended control, 2 size word |
| cfg_wdata | input | 16 | Write data (bits 7:0 for selects 0 and 1) |
| cfg_rd_sel | input | 2 | Register selected for read-back |
| cfg_rdata | output | 16 | Read-back value (combinational) |
| acc_valid | input | 1 | Access present |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | Access is a write |
| acc_smm | input | 1 | Access is issued in SMM |
| rsp_valid | output | 1 | Routing result valid |
| rsp_route | output | 2 | Destination: 0 DRAM, 1 PCI, 2 black hole |
| rsp_write | output | 1 | Write flag of the routed access |

## Verification
The main instance is built with LOW_TOP = 0x1000_0000 and EXT_MB = 16. With a 256 MB low top, every TSEG base (1, 2, 8 and 16 MB below the top) can be probed exactly at its edge with short constants. The extended code and the query handshake then map to a known 16 MB region. A second instance with EXT_MB = 0 shares the stimulus. It reaches the branch where the size word resets to 0 and a written query value is kept rather than replaced.

// File: rtl/smm_route_ctrl.sv
module smm_route_ctrl #(
  parameter int unsigned ADDR_W  = 32,
  parameter logic [31:0] LOW_TOP = 32'h8000_0000,
  parameter int unsigned EXT_MB  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_sel,
  input  logic [15:0]       cfg_wdata,
  input  logic [1:0]        cfg_rd_sel,
  output logic [15:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_smm,
  output logic              rsp_valid,
  output logic [1:0]        rsp_route,
  output logic              rsp_write
);
  localparam int unsigned AW1 = ADDR_W + 1;
  localparam logic [1:0] RT_DRAM = 2'd0;
  localparam logic [1:0] RT_PCI  = 2'd1;
  localparam logic [1:0] RT_BH   = 2'd2;
  localparam logic [15:0] QUERY  = 16'hFFFF;
  localparam logic [15:0] EXT_W  = 16'(EXT_MB);
  localparam logic [AW1-1:0] TOP = AW1'(LOW_TOP);
  localparam logic [AW1-1:0] LOW_LO  = AW1'(32'h000A_0000);
  localparam logic [AW1-1:0] LOW_HI  = AW1'(32'h000C_0000);
  localparam logic [AW1-1:0] HIGH_LO = AW1'(32'hFEDA_0000);
  localparam logic [AW1-1:0] HIGH_HI = AW1'(32'hFEDC_0000);

  logic       g_en, lock, open_b;
  logic       tseg_en, high_en;
  logic [1:0] sz_code;
  logic [15:0] ext_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_en <= 1'b0; lock <= 1'b0; open_b <= 1'b0;
      tseg_en <= 1'b0; high_en <= 1'b0; sz_code <= 2'd0;
      ext_word <= (EXT_MB != 0) ? QUERY : 16'h0;
    end else if (cfg_wr_en) begin
      case (cfg_sel)
        2'd0: if (!lock) begin
          g_en   <= cfg_wdata[0];
          lock   <= cfg_wdata[1];
          open_b <= cfg_wdata[2] & ~cfg_wdata[1];
        end
        2'd1: if (!lock) begin
          tseg_en <= cfg_wdata[0];
          sz_code <= cfg_wdata[2:1];
          high_en <= cfg_wdata[3];
        end
        2'd2: ext_word <= (EXT_MB != 0 && cfg_wdata == QUERY) ? EXT_W : cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_rd_sel)
      2'd0:    cfg_rdata = {13'd0, open_b, lock, g_en};
      2'd1:    cfg_rdata = {12'd0, high_en, sz_code, tseg_en};
      2'd2:    cfg_rdata = ext_word;
      default: cfg_rdata = 16'd0;
    endcase
  end

  logic [AW1-1:0] tseg_sz, tseg_base, addr_x;
  always_comb begin
    case (sz_code)
      2'd0:    tseg_sz = AW1'(1) << 20;
      2'd1:    tseg_sz = AW1'(2) << 20;
      2'd2:    tseg_sz = AW1'(8) << 20;
      default: tseg_sz = AW1'(EXT_MB) << 20;
    endcase
  end
  assign tseg_base = (tseg_sz > TOP) ? '0 : TOP - tseg_sz;
  assign addr_x    = {1'b0, acc_addr};

  wire in_low  = addr_x >= LOW_LO  && addr_x < LOW_HI;
  wire in_high = addr_x >= HIGH_LO && addr_x < HIGH_HI;
  wire in_tseg = tseg_en && tseg_sz != '0 && addr_x >= tseg_base && addr_x < TOP;

  logic [1:0] rt_plain, rt_final;
  always_comb begin
    if (in_tseg)      rt_plain = RT_BH;
    else if (in_low)  rt_plain = (open_b && !high_en) ? RT_DRAM : RT_PCI;
    else if (in_high) rt_plain = (open_b &&  high_en) ? RT_DRAM : RT_PCI;
    else              rt_plain = (addr_x < TOP) ? RT_DRAM : RT_PCI;
  end

  always_comb begin
    rt_final = rt_plain;
    if (acc_smm) begin
      if (in_tseg)                            rt_final = RT_DRAM;
      else if (in_low  && g_en && !high_en)   rt_final = RT_DRAM;
      else if (in_high && g_en &&  high_en)   rt_final = RT_DRAM;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_route <= RT_DRAM; rsp_write <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      if (acc_valid) begin
        rsp_route <= rt_final;
        rsp_write <= acc_write;
      end
    end
  end

  AST_ROUTE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_route != 2'd3); // R2
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid); // R2
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock); // R8
  AST_LOCK_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !open_b); // R8
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable({g_en, tseg_en, sz_code, high_en})); // R8
  AST_QUERY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_sel == 2'd2 && cfg_wdata == QUERY && EXT_MB != 0)
      |=> ext_word == EXT_W); // R9
endmodule

// File: tb/test_smm_route_ctrl.sv
`timescale 1ns/1ps
module test_smm_route_ctrl;
  localparam int unsigned AW = 32;
  localparam logic [1:0] DR = 2'd0, PC = 2'd1, BH = 2'd2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [1:0] cfg_sel = 2'd0, cfg_rd_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_smm = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [15:0] cfg_rdata, rdata2;
  logic rsp_valid, rsp_write, rv2, rw2;
  logic [1:0] rsp_route, rr2;

  smm_route_ctrl #(.ADDR_W(AW), .LOW_TOP(32'h1000_0000), .EXT_MB(16)) i_smm_route_ctrl (
    .clk, .rst_n, .cfg_wr_en, .cfg_sel, .cfg_wdata, .cfg_rd_sel, .cfg_rdata,
    .acc_valid, .acc_addr, .acc_write, .acc_smm, .rsp_valid, .rsp_route, .rsp_write);

  smm_route_ctrl #(.ADDR_W(AW), .LOW_TOP(32'h1000_0000), .EXT_MB(0)) i_noext (
    .clk, .rst_n, .cfg_wr_en, .cfg_sel, .cfg_wdata, .cfg_rd_sel, .cfg_rdata(rdata2),
    .acc_valid, .acc_addr, .acc_write, .acc_smm, .rsp_valid(rv2), .rsp_route(rr2), .rsp_write(rw2));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [1:0] exp_q[$];
  logic       expw_q[$];
  string      tag_q[$];
  logic [31:0] adr_q[$];

  task automatic access(input logic [31:0] a, input bit w, input bit s,
                        input logic [1:0] exp, input string tag);
    @(negedge clk);
    cfg_wr_en = 0; acc_valid = 1; acc_addr = a; acc_write = w; acc_smm = s;
    exp_q.push_back(exp); expw_q.push_back(w); tag_q.push_back(tag); adr_q.push_back(a);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 0; cfg_wr_en = 1; cfg_sel = sel; cfg_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0; cfg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    idle();
    cfg_rd_sel = sel; #1;
    n_cmp++;
    if (cfg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s reg%0d actual %h expected %h", tag, sel, cfg_rdata, exp);
    end
  endtask

  task automatic rd2(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    idle();
    cfg_rd_sel = sel; #1;
    n_cmp++;
    if (rdata2 !== exp) begin
      n_bad++;
      $display("FAIL %s noext reg%0d actual %h expected %h", tag, sel, rdata2, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; acc_valid = 0; cfg_wr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2 unexpected response actual %0d expected none", rsp_route);
      end else begin
        automatic logic [1:0] e = exp_q.pop_front();
        automatic logic ew = expw_q.pop_front();
        automatic string t = tag_q.pop_front();
        automatic logic [31:0] a = adr_q.pop_front();
        n_cmp++;
        if (rsp_route !== e || rsp_write !== ew) begin
          n_bad++;
          $display("FAIL %s addr %h actual route %0d/w%0d expected %0d/w%0d",
                   t, a, rsp_route, rsp_write, e, ew);
        end
      end
    end
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(2'd0, 16'h0000, "R1");
    rd(2'd1, 16'h0000, "R1");
    rd(2'd2, 16'hFFFF, "R1");
    rd2(2'd2, 16'h0000, "R1");
    // R2 default routing, R3/R5 closed windows
    access(32'h0000_0100, 0, 0, DR, "R2");
    access(32'h2000_0000, 1, 0, PC, "R2");
    access(32'h000A_0000, 0, 0, PC, "R3");
    access(32'h000A_0000, 0, 1, PC, "R5");
    access(32'h0FFF_FFFF, 0, 0, DR, "R7");
    // open + global enable; R10 next-cycle effect
    wr(2'd0, 16'h0005);
    access(32'h000A_0000, 0, 0, DR, "R10");
    access(32'h000B_FFFF, 1, 0, DR, "R3");
    access(32'h0009_FFFF, 0, 0, DR, "R2");
    access(32'hFEDA_0000, 0, 0, PC, "R4");
    access(32'h000A_0000, 0, 1, DR, "R5");
    // high enable
    wr(2'd1, 16'h0008);
    access(32'h000A_0000, 0, 0, PC, "R3");
    access(32'hFEDA_0000, 0, 0, DR, "R4");
    access(32'hFEDB_FFFF, 1, 0, DR, "R4");
    access(32'hFEDC_0000, 0, 0, PC, "R4");
    access(32'hFEDA_0000, 0, 1, DR, "R5");
    access(32'h000A_0000, 0, 1, PC, "R5");
    // close open, keep global enable
    wr(2'd0, 16'h0001);
    access(32'hFEDA_0000, 0, 0, PC, "R4");
    access(32'hFEDA_0000, 0, 1, DR, "R5");
    access(32'h000A_0000, 0, 1, PC, "R5");
    wr(2'd0, 16'h0000);
    access(32'hFEDA_0000, 0, 1, PC, "R5");
    // TSEG sizes (LOW_TOP = 0x1000_0000)
    wr(2'd1, 16'h0001);
    access(32'h0FF0_0000, 0, 0, BH, "R6");
    access(32'h0FF0_0000, 1, 0, BH, "R7");
    access(32'h0FEF_FFFF, 0, 0, DR, "R6");
    access(32'h0FFF_FFFF, 1, 0, BH, "R7");
    access(32'h0FF0_0000, 1, 1, DR, "R7");
    wr(2'd1, 16'h0003);
    access(32'h0FE0_0000, 0, 0, BH, "R6");
    access(32'h0FDF_FFFF, 0, 0, DR, "R6");
    wr(2'd1, 16'h0005);
    access(32'h0F80_0000, 0, 0, BH, "R6");
    access(32'h0F7F_FFFF, 0, 0, DR, "R6");
    wr(2'd1, 16'h0007);
    access(32'h0F00_0000, 0, 0, BH, "R6");
    access(32'h0EFF_FFFF, 0, 0, DR, "R6");
    access(32'h0F00_0000, 0, 1, DR, "R7");
    access(32'h1000_0000, 0, 0, PC, "R7");
    wr(2'd1, 16'h0006);
    access(32'h0F00_0000, 0, 0, DR, "R7");
    // R9 query handshake
    wr(2'd2, 16'h1234);
    rd(2'd2, 16'h1234, "R9");
    wr(2'd2, 16'hFFFF);
    rd(2'd2, 16'h0010, "R9");
    rd2(2'd2, 16'hFFFF, "R9");
    wr(2'd2, 16'hFFFE);
    rd(2'd2, 16'hFFFE, "R9");
    // R8 lock
    wr(2'd1, 16'h0007);
    wr(2'd0, 16'h0007);
    rd(2'd0, 16'h0003, "R8");
    access(32'h000A_0000, 0, 0, PC, "R8");
    access(32'h000A_0000, 0, 1, DR, "R8");
    wr(2'd0, 16'h0005);
    rd(2'd0, 16'h0003, "R8");
    wr(2'd1, 16'h0000);
    rd(2'd1, 16'h0007, "R8");
    access(32'h0F00_0000, 0, 0, BH, "R8");
    idle(); idle(); idle();
    do_reset();
    rd(2'd0, 16'h0000, "R8");
    rd(2'd1, 16'h0000, "R1");
    rd(2'd2, 16'hFFFF, "R1");
    idle(); idle();
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 missing responses actual %0d pending expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule